// File: doc/BRIEF.md
# Multiplexed Parallel Register Bus Slave

This block sits between a microcontroller's 8-bit multiplexed address/data bus and a small internal register file. The host first places an address on the shared bus while the address latch enable is high. It then runs one or more data phases with the active-low read or write strobe while chip select is low. Bit 7 of the latched address sets the direction: set for writes, clear for reads. The address stays latched, so back-to-back data phases reuse it without a new address cycle.

Every pin is asynchronous to the system clock. The block passes the pins through a two-flop synchronizer and acts on strobe edges. A write commits when the write strobe is released. Read data and the bus output enable appear after the read strobe is asserted. The register file holds a drive register whose bits become the eight channel output-enable lines. It also holds a read-only error status register, taken from an input, and a few scratch registers. Reading the status register sends a one-cycle clear request to the error logic.

A static strap selects a direct mode. If chip select, write strobe and address latch enable are low and read strobe is high while reset is applied, the outputs follow the bus pins and the bus protocol is ignored. An active-low output-disable input turns all outputs off at once, in either mode, and clears the drive register.

Top module: `pbus_slave`

## Requirements
- R1: While and immediately after synchronous reset (normal straps), drv_out is 00h, ad_oe is 0 and err_clr is 0.
- R2: With cs_n low and ale high, the value on ad_in is latched as the address, and all later data phases with ale low use that latched address until the next address phase, including repeated reads and repeated writes.
- R3: When the latched address has bit 7 = 1, a write strobe pulse (wr_n low, then high) with cs_n low stores the ad_in value held during the pulse into register index addr[6:0]. Index 0 (address 80h) is the drive register, and its value appears on drv_out within 4 clock cycles after wr_n rises.
- R4: When the latched address has bit 7 = 0, asserting rd_n with cs_n low raises ad_oe and presents on ad_out the register at index addr[6:0]: 00h reads the drive register, 04h reads the err_status input, 08h..0Bh read the scratch registers.
- R5: ad_oe is 0 whenever cs_n or rd_n is high, and it stays 0 for a read strobe while the latched address has bit 7 = 1.
- R6: A write strobe while the latched address has bit 7 = 0 changes no register.
- R7: Reads of unmapped indices return 00h. Writes to unmapped indices and to the status index 4 (address 84h) have no effect.
- R8: A read of address 04h makes err_clr high for exactly one clock cycle. Reads of other addresses never raise err_clr.
- R9: odis_n low forces drv_out to 00h in the same cycle, without waiting for a clock. It also clears the drive register, so drv_out stays 00h after odis_n returns high.
- R10: If cs_n, wr_n and ale are low and rd_n is high during reset, the block enters direct mode after reset. drv_out then follows ad_in within 4 cycles, ad_oe stays 0, and odis_n low still forces drv_out to 00h.
- R11: Scratch registers at write addresses 88h..8Bh keep the values written to them, and those values read back at 08h..0Bh.
- R12: With cs_n high, address phases and write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled during it |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address latch enable, high during address phase |
| odis_n | input | 1 | Output disable, active low, overrides everything |
| ad_in | input | 8 | Bus value from pins |
| err_status | input | 8 | Global error status shown at read address 04h |
| ad_out | output | 8 | Read data toward the pins |
| ad_oe | output | 1 | Bus output enable for ad_out |
| drv_out | output | 8 | Channel output-enable bits |
| err_clr | output | 1 | One-cycle clear request after a status read |

## Verification
The bench issues several data phases after a single address phase. A design that re-latched the address or dropped it would write the wrong register or return stale reads. It writes with a read-direction address, reads with a write-direction address, and writes to the status and unmapped indices. A direction-decode bug would then corrupt a register, or drive the bus when it must stay off. It pulses output-disable and then checks that drive stays off after release, which catches a design that only gates the output but never clears the register. A second reset with the direct-mode straps shows whether the strap is captured, and whether output-disable still wins over the pin-following path.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int PB_DATA_W       = 8;
    localparam int PB_IDX_W        = PB_DATA_W - 1;
    localparam int PB_DRIVE_IDX    = 0;
    localparam int PB_STATUS_IDX   = 4;
    localparam int PB_SCRATCH_BASE = 8;
    localparam int PB_NUM_SCRATCH  = 4;
    localparam int PB_SYNC_STAGES  = 2;

    typedef struct packed {
        logic cs;
        logic rd;
        logic wr;
        logic ale;
        logic odis_ok;
    } strobe_t;

    localparam int PB_STROBE_W = $bits(strobe_t);

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    function automatic acc_e decode_access(input logic bus_ok,
                                           input logic rd_start,
                                           input logic wr_end,
                                           input logic dir_msb);
        if (bus_ok && rd_start && !dir_msb)
            return ACC_READ;
        else if (bus_ok && wr_end && dir_msb)
            return ACC_WRITE;
        return ACC_NONE;
    endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d_async;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
    import pbus_pkg::*;
#(
    parameter int NUM_SCRATCH = PB_NUM_SCRATCH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 direct_load,
    input  logic [PB_DATA_W-1:0] direct_data,
    input  logic                 wr_en,
    input  logic [PB_IDX_W-1:0]  wr_idx,
    input  logic [PB_DATA_W-1:0] wr_data,
    input  logic [PB_IDX_W-1:0]  rd_idx,
    input  logic [PB_DATA_W-1:0] status_in,
    output logic [PB_DATA_W-1:0] rd_data,
    output logic [PB_DATA_W-1:0] drive
);

    localparam logic [PB_IDX_W-1:0] DRIVE_IDX  = PB_IDX_W'(PB_DRIVE_IDX);
    localparam logic [PB_IDX_W-1:0] STATUS_IDX = PB_IDX_W'(PB_STATUS_IDX);

    logic [PB_DATA_W-1:0] scratch_q [NUM_SCRATCH];

    always_ff @(posedge clk) begin
        if (rst)
            drive <= '0;
        else if (clear)
            drive <= '0;
        else if (direct_load)
            drive <= direct_data;
        else if (wr_en && wr_idx == DRIVE_IDX)
            drive <= wr_data;
    end

    generate
        for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scratch
            always_ff @(posedge clk) begin
                if (rst)
                    scratch_q[g] <= '0;
                else if (wr_en && wr_idx == PB_IDX_W'(PB_SCRATCH_BASE + g))
                    scratch_q[g] <= wr_data;
            end

            // R11: a scratch register changes only through a write
            p_scratch_hold_r11: assert property (@(posedge clk) disable iff (rst)
                !$stable(scratch_q[g]) |-> $past(wr_en));
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_idx == DRIVE_IDX)
            rd_data = drive;
        else if (rd_idx == STATUS_IDX)
            rd_data = status_in;
        else
            for (int i = 0; i < NUM_SCRATCH; i++)
                if (rd_idx == PB_IDX_W'(PB_SCRATCH_BASE + i))
                    rd_data = scratch_q[i];
    end

    // R3: drive changes only by a drive write, a clear or a direct load
    p_drive_cause_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(drive) |-> $past(clear || direct_load || (wr_en && wr_idx == DRIVE_IDX)));

    // R9: a clear leaves drive empty
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> drive == '0);

endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
    import pbus_pkg::*;
#(
    parameter int NUM_SCRATCH = PB_NUM_SCRATCH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 ale,
    input  logic                 odis_n,
    input  logic [PB_DATA_W-1:0] ad_in,
    input  logic [PB_DATA_W-1:0] err_status,
    output logic [PB_DATA_W-1:0] ad_out,
    output logic                 ad_oe,
    output logic [PB_DATA_W-1:0] drv_out,
    output logic                 err_clr
);

    localparam int SW = PB_STROBE_W + PB_DATA_W;
    localparam logic [PB_IDX_W-1:0] STATUS_IDX = PB_IDX_W'(PB_STATUS_IDX);

    logic [SW-1:0]        raw_pins;
    logic [SW-1:0]        syn_pins;
    strobe_t              st;
    logic [PB_DATA_W-1:0] ad_s;

    assign raw_pins = {~cs_n, ~rd_n, ~wr_n, ale, odis_n, ad_in};

    pbus_sync #(.W(SW), .STAGES(PB_SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_pins),
        .q_sync  (syn_pins)
    );

    assign st   = strobe_t'(syn_pins[SW-1 -: PB_STROBE_W]);
    assign ad_s = syn_pins[PB_DATA_W-1:0];

    logic rd_prev, wr_prev, direct_q;
    logic [PB_DATA_W-1:0] addr_q, wdata_q, rdata_q, rf_rd;
    logic [PB_DATA_W-1:0] rf_drive;
    logic rd_valid_q, err_clr_q;
    logic rd_start, wr_end, bus_ok;
    acc_e acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev  <= 1'b0;
            wr_prev  <= 1'b0;
            direct_q <= ~cs_n & ~wr_n & ~ale & rd_n;
        end else begin
            rd_prev  <= st.rd;
            wr_prev  <= st.wr;
        end
    end

    assign rd_start = st.rd & ~rd_prev;
    assign wr_end   = ~st.wr & wr_prev;
    assign bus_ok   = st.cs & ~st.ale & ~direct_q;
    assign acc      = decode_access(bus_ok, rd_start, wr_end, addr_q[PB_DATA_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (st.cs && st.ale && !direct_q)
                addr_q <= ad_s;
            if (st.wr && bus_ok)
                wdata_q <= ad_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q    <= '0;
            rd_valid_q <= 1'b0;
            err_clr_q  <= 1'b0;
        end else begin
            err_clr_q <= 1'b0;
            if (acc == ACC_READ) begin
                rdata_q    <= rf_rd;
                rd_valid_q <= 1'b1;
                err_clr_q  <= (addr_q[PB_IDX_W-1:0] == STATUS_IDX);
            end else if (!(st.rd && st.cs)) begin
                rd_valid_q <= 1'b0;
            end
        end
    end

    pbus_regfile #(.NUM_SCRATCH(NUM_SCRATCH)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .clear       (~st.odis_ok),
        .direct_load (direct_q),
        .direct_data (ad_s),
        .wr_en       (acc == ACC_WRITE),
        .wr_idx      (addr_q[PB_IDX_W-1:0]),
        .wr_data     (wdata_q),
        .rd_idx      (addr_q[PB_IDX_W-1:0]),
        .status_in   (err_status),
        .rd_data     (rf_rd),
        .drive       (rf_drive)
    );

    assign ad_out  = rdata_q;
    assign ad_oe   = rd_valid_q & st.cs & st.rd;
    assign err_clr = err_clr_q;
    assign drv_out = (odis_n && st.odis_ok) ? rf_drive : '0;

    // R8: the clear request is a single-cycle pulse
    p_clr_single_r8: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> !err_clr);

    // R8: the clear request only follows a read of the status address
    p_clr_addr_r8: assert property (@(posedge clk) disable iff (rst)
        err_clr |-> (addr_q[PB_IDX_W-1:0] == STATUS_IDX && !addr_q[PB_DATA_W-1]));

    // R10: the bus is never driven in direct mode
    p_direct_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        direct_q |-> !ad_oe);

    // R5: bus drive only while a read strobe is seen under chip select
    p_oe_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (rd_prev && !addr_q[PB_DATA_W-1]));

endmodule

// File: tb/pbus_slave_tb_top.sv
module pbus_slave_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0, odis_n = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] err_status = 8'h5A;
    logic [7:0] ad_out, drv_out;
    logic       ad_oe, err_clr;

    int checks = 0;
    int errors = 0;
    int clr_count = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_slave dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ale(ale), .odis_n(odis_n), .ad_in(ad_in), .err_status(err_status),
        .ad_out(ad_out), .ad_oe(ad_oe), .drv_out(drv_out), .err_clr(err_clr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data when the bus enable rises
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (err_clr) clr_count++;
            if (ad_oe && !prev_oe) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected bus drive", 8'h01, 8'h00);
                end else begin
                    chk(tag_q.pop_front(), ad_out, exp_q.pop_front());
                end
            end
        end
        prev_oe = ad_oe;
    end

    task automatic set_addr(input logic [7:0] a);
        cs_n = 1'b0; ale = 1'b1; ad_in = a;
        repeat (4) @(negedge clk);
        ale = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wdata(input logic [7:0] d);
        ad_in = d; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic rdata(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_n = 1'b0;
        repeat (6) @(negedge clk);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic release_cs();
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int clr_before;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 drv_out after reset", drv_out, 8'h00);
        chk("R1 ad_oe after reset", {7'b0, ad_oe}, 8'h00);
        chk("R1 err_clr after reset", {7'b0, err_clr}, 8'h00);
        repeat (4) @(negedge clk);

        // R3 write drive, R2 second data phase reuses the address
        set_addr(8'h80);
        wdata(8'h0F);
        chk("R3 drive write", drv_out, 8'h0F);
        wdata(8'h0A);
        chk("R2 reused address write", drv_out, 8'h0A);
        release_cs();

        // R4 reads, R8 clear pulse on status read
        set_addr(8'h00);
        rdata(8'h0A, "R4 read drive");
        chk("R8 no clear on drive read", clr_count[7:0], 8'h00);
        set_addr(8'h04);
        rdata(8'h5A, "R4 read status");
        chk("R8 clear pulse on status read", clr_count[7:0], 8'h01);
        release_cs();

        // R11 scratch
        set_addr(8'h88); wdata(8'hC3);
        set_addr(8'h8B); wdata(8'h3C);
        set_addr(8'h08); rdata(8'hC3, "R11 scratch 0");
        set_addr(8'h0B); rdata(8'h3C, "R11 scratch 3");
        // R2 repeated reads with one address phase
        set_addr(8'h08);
        rdata(8'hC3, "R2 repeated read 1");
        rdata(8'hC3, "R2 repeated read 2");

        // R6 writes with read-direction address are ignored
        set_addr(8'h08); wdata(8'hFF);
        set_addr(8'h00); wdata(8'hFF);
        chk("R6 drive unchanged", drv_out, 8'h0A);
        set_addr(8'h08); rdata(8'hC3, "R6 scratch unchanged");

        // R7 unmapped and status writes ignored
        clr_before = clr_count;
        set_addr(8'h90); wdata(8'h77);
        set_addr(8'h10); rdata(8'h00, "R7 unmapped read");
        chk("R8 no clear on unmapped read", 8'(clr_count - clr_before), 8'h00);
        set_addr(8'h84); wdata(8'h11);
        set_addr(8'h04); rdata(8'h5A, "R7 status not writable");
        chk("R8 second status clear", 8'(clr_count - clr_before), 8'h01);

        // R5 read strobe with write-direction address: no drive
        set_addr(8'h80);
        rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 no drive on write address", {7'b0, ad_oe}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R5 no drive on write address late", {7'b0, ad_oe}, 8'h00);
        rd_n = 1'b1;
        release_cs();
        chk("R5 idle bus", {7'b0, ad_oe}, 8'h00);

        // R12 chip select high: everything ignored
        ale = 1'b1; ad_in = 8'h80;
        repeat (4) @(negedge clk);
        ale = 1'b0;
        repeat (3) @(negedge clk);
        wdata(8'h55);
        chk("R12 write ignored without cs", drv_out, 8'h0A);

        // R9 output disable
        @(negedge clk);
        odis_n = 1'b0;
        #1;
        chk("R9 immediate off", drv_out, 8'h00);
        repeat (5) @(negedge clk);
        odis_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 drive cleared", drv_out, 8'h00);
        chk("R4 all reads popped", 8'(exp_q.size()), 8'h00);

        // R10 direct mode strap
        rst = 1'b1;
        cs_n = 1'b0; wr_n = 1'b0; ale = 1'b0; rd_n = 1'b1; ad_in = 8'hA5;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 direct follow", drv_out, 8'hA5);
        ad_in = 8'h3C;
        repeat (4) @(negedge clk);
        chk("R10 direct follow change", drv_out, 8'h3C);
        chk("R10 bus off in direct", {7'b0, ad_oe}, 8'h00);
        odis_n = 1'b0;
        #1;
        chk("R10 odis overrides direct", drv_out, 8'h00);
        repeat (3) @(negedge clk);
        odis_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule